// File: doc/BRIEF.md
# Signed/Unsigned Multiply-Accumulate Unit

This block is a 16x16 multiplier that feeds a 40-bit accumulator. A control register selects one of four operations. Multiply and multiply-negate load the accumulator with the product or its negation. Multiply-accumulate and multiply-subtract add the product to the accumulator or take it away. A second control bit makes the unit treat both operands as signed or as unsigned. The 8 guard bits above the 32-bit product let long signed sums run without wrapping. A flag records a wrap when one does happen.

Software reaches the unit through a small register bus: a write strobe, a 4-bit address, 16-bit write data and 16-bit combinational read data. Software sets the operation mode and the first operand. Writing the second operand starts the operation. The accumulator, the raw product and the overflow flag update at that same clock edge and can be read in the next cycle. The accumulator can also be loaded word by word, or cleared with a single write.

Top module: `mac40_unit`

## Requirements
- R1: After reset, every readable register reads 0.
- R2: The registers sit at addresses 0h (mode), 1h (operand A), 2h (operand B), 3h/4h/5h (accumulator bits 15:0, 31:16, 39:32), 7h/8h (product bits 15:0, 31:16), 9h (status) and Eh (clear). Every other address reads 0, and writes to it have no effect.
- R3: Mode register bit 0 selects signed (1) or unsigned (0) operands. Bits 2:1 select the operation: 00 multiply, 01 multiply-negate, 10 multiply-accumulate, 11 multiply-subtract. The register reads back those three bits and 0 above them.
- R4: A write to operand B starts one operation. The operation uses the operand A register and the written value. Its results can be read in the cycle after the write, and a second start in the very next cycle builds on the first result.
- R5: Multiply replaces the accumulator with the product, sign-extended to 40 bits in signed mode and zero-extended in unsigned mode.
- R6: Multiply-negate replaces the accumulator with the negated extended product, modulo 2^40.
- R7: Multiply-accumulate adds the extended product to the accumulator, and multiply-subtract subtracts it, modulo 2^40.
- R8: Status bit 0 (address 9h) is set by an operation exactly when signed mode is active, the operation is accumulate or subtract, and the true result does not fit in 40-bit two's complement. Every other operation clears it.
- R9: Writes to 3h/4h/5h load the addressed accumulator field (only bits 7:0 at 5h, which reads 0 above them) and leave the status flag unchanged.
- R10: Any write to Eh clears the accumulator and the status flag. Eh reads 0.
- R11: Addresses 7h/8h hold the low 32 bits of the last product, in two's complement in signed mode. Writes to 7h, 8h and 9h are ignored.
- R12: Without a write, the accumulator, product and status registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
Two functions can meet at one clock edge: an operation's accumulator update and the next start, which reads that accumulator back as its addend. The bench provokes this with operand B writes on consecutive cycles, with no idle cycle between them. It judges the final accumulator against a reference model applied twice in sequence. Random signed and unsigned operands drive all four operations through the model. Loaded accumulator values next to the signed limits force the wrap flag both ways.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
    localparam int OPW   = 16;
    localparam int ACCW  = 40;
    localparam int PRODW = 2 * OPW;
    localparam int GRDW  = ACCW - PRODW;
    localparam int ADRW  = 4;

    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_MNEG = 2'b01,
        OP_MAC  = 2'b10,
        OP_MSUB = 2'b11
    } mac_op_e;

    localparam logic [ADRW-1:0] A_MODE = 4'h0;
    localparam logic [ADRW-1:0] A_OPA  = 4'h1;
    localparam logic [ADRW-1:0] A_OPB  = 4'h2;
    localparam logic [ADRW-1:0] A_ACC0 = 4'h3;
    localparam logic [ADRW-1:0] A_ACC1 = 4'h4;
    localparam logic [ADRW-1:0] A_ACC2 = 4'h5;
    localparam logic [ADRW-1:0] A_PRD0 = 4'h7;
    localparam logic [ADRW-1:0] A_PRD1 = 4'h8;
    localparam logic [ADRW-1:0] A_STAT = 4'h9;
    localparam logic [ADRW-1:0] A_CLR  = 4'hE;

    typedef struct packed {
        logic             sgn;
        mac_op_e          op;
        logic [OPW-1:0]   opa;
        logic [OPW-1:0]   opb;
        logic [ACCW-1:0]  acc;
        logic [PRODW-1:0] prod;
        logic             ovf;
    } mac_state_t;
endpackage

// File: rtl/mac40_mult.sv
module mac40_mult #(
    parameter int W = 16
) (
    input  logic [W-1:0]           a,
    input  logic [W-1:0]           b,
    input  logic                   sgn,
    output logic signed [2*W+1:0]  p
);
    logic signed [W:0] ax;
    logic signed [W:0] bx;

    always_comb begin
        ax = {sgn & a[W-1], a};
        bx = {sgn & b[W-1], b};
        p  = ax * bx;
    end
endmodule

// File: rtl/mac40_combine.sv
module mac40_combine
    import mac40_pkg::*;
#(
    parameter int PW = 34,
    parameter int AW = 40
) (
    input  logic signed [PW-1:0] p,
    input  logic [AW-1:0]        acc,
    input  mac_op_e              op,
    input  logic                 sgn,
    output logic [AW-1:0]        res,
    output logic                 ovf
);
    localparam int XW = AW - PW;

    logic [AW-1:0] pext;
    logic          sum_wrap;
    logic          dif_wrap;

    always_comb begin
        pext     = {{XW{p[PW-1]}}, p};
        res      = '0;
        unique case (op)
            OP_MUL:  res = pext;
            OP_MNEG: res = '0 - pext;
            OP_MAC:  res = acc + pext;
            OP_MSUB: res = acc - pext;
            default: res = pext;
        endcase
        sum_wrap = (acc[AW-1] == pext[AW-1]) && (res[AW-1] != acc[AW-1]);
        dif_wrap = (acc[AW-1] != pext[AW-1]) && (res[AW-1] != acc[AW-1]);
        ovf      = sgn && (((op == OP_MAC) && sum_wrap) || ((op == OP_MSUB) && dif_wrap));
    end
endmodule

// File: rtl/mac40_rdmux.sv
module mac40_rdmux
    import mac40_pkg::*;
(
    input  mac_state_t       st,
    input  logic [ADRW-1:0]  addr,
    output logic [OPW-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_MODE: rdata = {{(OPW-3){1'b0}}, st.op, st.sgn};
            A_OPA:  rdata = st.opa;
            A_OPB:  rdata = st.opb;
            A_ACC0: rdata = st.acc[OPW-1:0];
            A_ACC1: rdata = st.acc[PRODW-1:OPW];
            A_ACC2: rdata = {{(OPW-GRDW){1'b0}}, st.acc[ACCW-1:PRODW]};
            A_PRD0: rdata = st.prod[OPW-1:0];
            A_PRD1: rdata = st.prod[PRODW-1:OPW];
            A_STAT: rdata = {{(OPW-1){1'b0}}, st.ovf};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
    import mac40_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [3:0]      bus_addr,
    input  logic [15:0]     bus_wdata,
    output logic [15:0]     bus_rdata
);
    localparam int MPW = 2 * OPW + 2;

    mac_state_t            s_q;
    mac_state_t            s_d;
    logic signed [MPW-1:0] prod_full;
    logic [ACCW-1:0]       acc_next;
    logic                  ovf_next;

    logic [ACCW-1:0]       acc_w;
    logic [PRODW-1:0]      prod_w;
    logic                  ovf_w;
    logic                  sgn_w;
    logic [1:0]            op_w;

    mac40_mult #(.W(OPW)) mult_i (
        .a   (s_q.opa),
        .b   (bus_wdata),
        .sgn (s_q.sgn),
        .p   (prod_full)
    );

    mac40_combine #(.PW(MPW), .AW(ACCW)) comb_i (
        .p   (prod_full),
        .acc (s_q.acc),
        .op  (s_q.op),
        .sgn (s_q.sgn),
        .res (acc_next),
        .ovf (ovf_next)
    );

    mac40_rdmux rdmux_i (
        .st    (s_q),
        .addr  (bus_addr),
        .rdata (bus_rdata)
    );

    always_comb begin
        s_d = s_q;
        if (bus_we) begin
            unique case (bus_addr)
                A_MODE: begin
                    s_d.sgn = bus_wdata[0];
                    s_d.op  = mac_op_e'(bus_wdata[2:1]);
                end
                A_OPA: s_d.opa = bus_wdata;
                A_OPB: begin
                    s_d.opb  = bus_wdata;
                    s_d.acc  = acc_next;
                    s_d.prod = prod_full[PRODW-1:0];
                    s_d.ovf  = ovf_next;
                end
                A_ACC0: s_d.acc[OPW-1:0]       = bus_wdata;
                A_ACC1: s_d.acc[PRODW-1:OPW]   = bus_wdata;
                A_ACC2: s_d.acc[ACCW-1:PRODW]  = bus_wdata[GRDW-1:0];
                A_CLR: begin
                    s_d.acc = '0;
                    s_d.ovf = 1'b0;
                end
                default: s_d = s_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc_w  = s_q.acc;
    assign prod_w = s_q.prod;
    assign ovf_w  = s_q.ovf;
    assign sgn_w  = s_q.sgn;
    assign op_w   = s_q.op;
endmodule

// File: rtl/mac40_chk.sv
module mac40_chk
    import mac40_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             we,
    input logic [ADRW-1:0]  addr,
    input logic [OPW-1:0]   wdata,
    input logic [ACCW-1:0]  acc,
    input logic [PRODW-1:0] prod,
    input logic             ovf,
    input logic             sgn,
    input logic [1:0]       op
);
    // R8
    unsigned_noovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_OPB && !sgn) |=> !ovf);

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_CLR) |=> (acc == '0 && !ovf));

    // R11
    prod_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == A_PRD0 || addr == A_PRD1 || addr == A_STAT))
        |=> ($stable(prod) && $stable(acc)));

    // R12
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(acc) && $stable(ovf) && $stable(prod)));

    // R9
    accload_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == A_ACC0 || addr == A_ACC1 || addr == A_ACC2)) |=> $stable(ovf));

    // R5
    mul_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_OPB && wdata == '0 && (op == 2'b00 || op == 2'b01))
        |=> (acc == '0 && prod == '0));
endmodule

bind mac40_unit mac40_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .acc   (acc_w),
    .prod  (prod_w),
    .ovf   (ovf_w),
    .sgn   (sgn_w),
    .op    (op_w)
);

// File: tb/mac40_unit_tb_top.sv
module mac40_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int total = 0;
    int bad = 0;

    logic [39:0] m_acc;
    logic [31:0] m_prod;
    logic        m_ovf;

    always #2 clk = ~clk;

    mac40_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // stimulus table: {mode[2:0], operand A, operand B}
    localparam int NV = 10;
    localparam logic [34:0] VEC [NV] = '{
        {3'b001, 16'h0003, 16'h0007},
        {3'b101, 16'hFFFB, 16'h0009},
        {3'b111, 16'h8000, 16'h8000},
        {3'b011, 16'h1234, 16'hFFFF},
        {3'b000, 16'hFFFF, 16'hFFFF},
        {3'b100, 16'hFFFF, 16'hFFFF},
        {3'b110, 16'h00FF, 16'h0100},
        {3'b010, 16'h8000, 16'h0002},
        {3'b101, 16'h7FFF, 16'h7FFF},
        {3'b111, 16'h8000, 16'h7FFF}
    };

    function automatic logic [72:0] ref_op(logic [39:0] acc, logic [15:0] a,
                                           logic [15:0] b, logic sgn, logic [1:0] op);
        longint pa, pb, p, ac, r;
        logic [39:0] n;
        logic o;
        pa = sgn ? longint'($signed(a)) : longint'({48'd0, a});
        pb = sgn ? longint'($signed(b)) : longint'({48'd0, b});
        p  = pa * pb;
        ac = longint'($signed(acc));
        case (op)
            2'b00:   r = p;
            2'b01:   r = -p;
            2'b10:   r = ac + p;
            default: r = ac - p;
        endcase
        n = r[39:0];
        o = sgn && op[1] && (r != longint'($signed(n)));
        return {o, p[31:0], n};
    endfunction

    task automatic chk(input string tag, input logic [39:0] got, input logic [39:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_acc(output logic [39:0] v);
        logic [15:0] w0, w1, w2;
        rd(4'h3, w0); rd(4'h4, w1); rd(4'h5, w2);
        v = {w2[7:0], w1, w0};
    endtask

    task automatic do_op(input logic [2:0] mode, input logic [15:0] a, input logic [15:0] b);
        logic [72:0] r;
        wr(4'h0, {13'd0, mode});
        wr(4'h1, a);
        wr(4'h2, b);
        r = ref_op(m_acc, a, b, mode[0], mode[2:1]);
        m_acc = r[39:0]; m_prod = r[71:40]; m_ovf = r[72];
    endtask

    task automatic chk_model(input string tag);
        logic [39:0] v;
        logic [15:0] p0, p1, st;
        rd_acc(v);
        chk({tag, " acc"}, v, m_acc);
        rd(4'h7, p0); rd(4'h8, p1);
        chk({tag, " prod R11"}, {8'd0, p1, p0}, {8'd0, m_prod});
        rd(4'h9, st);
        chk({tag, " ovf R8"}, {39'd0, st[0]}, {39'd0, m_ovf});
    endtask

    initial begin
        #800000;
        bad++; total++;
        $display("FAIL watchdog: got=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [39:0] v;
        m_acc = '0; m_prod = '0; m_ovf = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state across all addresses
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), d);
            chk($sformatf("R1 reset addr %0h", i), {24'd0, d}, 40'd0);
        end

        // R3 mode readback, upper bits dropped
        wr(4'h0, 16'hFFF3);
        rd(4'h0, d);
        chk("R3 mode readback", {24'd0, d}, 40'h3);
        wr(4'hE, 16'h0000);

        // R5 R6 R7 table walk against reference
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][34:32], VEC[i][31:16], VEC[i][15:0]);
            chk_model($sformatf("R5/R6/R7 vec %0d", i));
        end

        // R5 directed: signed -1*2, unsigned 0xFFFF*2
        do_op(3'b001, 16'hFFFF, 16'h0002);
        rd_acc(v); chk("R5 signed mul", v, 40'hFF_FFFF_FFFE);
        do_op(3'b000, 16'hFFFF, 16'h0002);
        rd_acc(v); chk("R5 unsigned mul", v, 40'h00_0001_FFFE);

        // R6 directed: unsigned 1*1 negated
        do_op(3'b010, 16'h0001, 16'h0001);
        rd_acc(v); chk("R6 unsigned neg", v, 40'hFF_FFFF_FFFF);

        // R9 accumulator load keeps flag; R8 signed wrap at top
        wr(4'h3, 16'hFFFF); wr(4'h4, 16'hFFFF); wr(4'h5, 16'hFF7F);
        rd(4'h5, d); chk("R9 acc hi field", {24'd0, d}, 40'h7F);
        m_acc = 40'h7F_FFFF_FFFF;
        do_op(3'b101, 16'h0001, 16'h0001);
        rd_acc(v); chk("R7 mac wrap value", v, 40'h80_0000_0000);
        rd(4'h9, d); chk("R8 signed wrap flag", {39'd0, d[0]}, 40'd1);
        wr(4'h3, 16'h0000);
        rd(4'h9, d); chk("R9 flag kept on acc load", {39'd0, d[0]}, 40'd1);

        // R8 unsigned same wrap: no flag
        wr(4'h3, 16'hFFFF); wr(4'h4, 16'hFFFF); wr(4'h5, 16'h007F);
        do_op(3'b100, 16'h0001, 16'h0001);
        rd_acc(v); chk("R7 unsigned mac", v, 40'h80_0000_0000);
        rd(4'h9, d); chk("R8 unsigned no flag", {39'd0, d[0]}, 40'd0);

        // R8 signed subtract wrap at bottom
        m_acc = 40'h80_0000_0000;
        do_op(3'b111, 16'h0001, 16'h0001);
        rd_acc(v); chk("R7 msub wrap value", v, 40'h7F_FFFF_FFFF);
        rd(4'h9, d); chk("R8 msub wrap flag", {39'd0, d[0]}, 40'd1);

        // R10 clear
        wr(4'hE, 16'h1234);
        rd_acc(v); chk("R10 clear acc", v, 40'd0);
        rd(4'h9, d); chk("R10 clear flag", {39'd0, d[0]}, 40'd0);
        rd(4'hE, d); chk("R10 clear reads 0", {24'd0, d}, 40'd0);
        m_acc = '0; m_ovf = 1'b0;

        // R11 R2 writes to read-only and unused addresses ignored
        do_op(3'b001, 16'h0102, 16'h0304);
        wr(4'h7, 16'hAAAA); wr(4'h8, 16'h5555); wr(4'h9, 16'hFFFF);
        wr(4'h6, 16'hFFFF); wr(4'hF, 16'hFFFF);
        chk_model("R11 R2 ignored writes");
        rd(4'h6, d); chk("R2 unused reads 0", {24'd0, d}, 40'd0);

        // R4 R12 back-to-back starts with no idle cycle
        wr(4'h0, 16'h0005);
        wr(4'h1, 16'h0010);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'h2; bus_wdata = 16'h0020;
        @(negedge clk);
        bus_wdata = 16'hFFF0;
        @(negedge clk);
        bus_we = 1'b0;
        begin
            logic [72:0] r;
            r = ref_op(m_acc, 16'h0010, 16'h0020, 1'b1, 2'b10);
            r = ref_op(r[39:0], 16'h0010, 16'hFFF0, 1'b1, 2'b10);
            m_acc = r[39:0]; m_prod = r[71:40]; m_ovf = r[72];
        end
        chk_model("R4 back-to-back mac");
        rd(4'h2, d); chk("R4 opb readback", {24'd0, d}, 40'hFFF0);
        repeat (5) @(negedge clk);
        chk_model("R12 hold when idle");

        // R5 R6 R7 R8 random operands in every mode
        for (int i = 0; i < 200; i++) begin
            logic [2:0] md;
            md = 3'($urandom_range(0, 7));
            if (i % 17 == 0) begin
                logic [39:0] seed;
                seed = {8'($urandom), 32'($urandom)};
                wr(4'h3, seed[15:0]); wr(4'h4, seed[31:16]); wr(4'h5, {8'd0, seed[39:32]});
                m_acc = seed;
            end
            do_op(md, 16'($urandom), 16'($urandom));
            chk_model($sformatf("R5/R6/R7/R8 random %0d", i));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule